// File: doc/BRIEF.md
# Saturate and halfword pack unit

This is a datapath block with a registered output. It clamps a 32-bit signed value to a programmable bit width, or it packs halfwords from two operands. In the saturate operations the value can be pre-shifted before it is clamped. A dual form clamps each 16-bit half of the operand on its own. Two pack operations each build a word from one half of the first operand and one half of a shifted second operand. Whenever a lane was clamped, a one-cycle saturation pulse is raised beside the result, so that a sticky flag held elsewhere can be set.

A new operation may be presented every cycle. The result and the pulse appear after the next rising clock edge.

Top module: `sat_pack_unit`

## Requirements
- R1: While reset is active, and after it is released until the first rising edge, `result_o` is 0 and `sat_o` is 0.
- R2: `result_o` and `sat_o` show the operation whose inputs were sampled at the preceding rising clock edge, so the latency is one cycle.
- R3: Opcode 0 is signed word clamp. The shifted operand is clamped to n = `imm_i`+1 bits, which is the range -2^(n-1) to 2^(n-1)-1. With `imm_i`=31 and no shift, the operand passes through unchanged.
- R4: Opcode 1 is unsigned word clamp. The shifted operand, read as signed, is clamped to the range 0 to 2^n-1, where n = `imm_i`.
- R5: The pre-shift applies to opcodes 0 and 1. `shtype_i`=0 shifts `a_i` left logically by `shamt_i`. `shtype_i`=1 shifts it right arithmetically by `shamt_i`, and an amount of 0 means a shift by 32, which gives all sign bits.
- R6: Opcode 2 is signed dual-half clamp. Bits [31:16] and [15:0] of `a_i` are each clamped as signed values to n = `imm_i[3:0]`+1 bits. `imm_i[4]`, the shift type and the shift amount have no effect.
- R7: Opcode 3 is unsigned dual-half clamp. Each signed half is clamped to the range 0 to 2^n-1, where n = `imm_i[3:0]`.
- R8: Opcode 4 is bottom-top pack. The result is {(`b_i` << `shamt_i`)[31:16], `a_i`[15:0]}. `shtype_i` has no effect.
- R9: Opcode 5 is top-bottom pack. The result is {`a_i`[31:16], (`b_i` >>> `shamt_i`)[15:0]}, with an arithmetic right shift in which an amount of 0 means 32. `shtype_i` has no effect.
- R10: `sat_o` is 1 exactly when at least one lane of a clamp operation was limited. It is never 1 for a pack operation.
- R11: Opcodes 6 and 7 give a result of 0 with `sat_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (see R3 to R11) |
| imm_i | input | 5 | Saturation width immediate |
| shtype_i | input | 1 | Pre-shift type: 0 left logical, 1 right arithmetic |
| shamt_i | input | 5 | Shift amount |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, used by the packs |
| result_o | output | 32 | Registered result |
| sat_o | output | 1 | Registered saturation pulse |

## Verification
The only state in the block is its output register, so any error appears at the ports one cycle after the operation that causes it. It shows up as a wrong result word or a wrong saturation pulse. The most sensitive points are the boundaries of the clamp. These are a value exactly at a limit against one step past it, the n=1 and n=0 extremes, and an arithmetic shift amount of zero. A wrong bound or a wrong shift decode shows up on the first operation that crosses such a boundary. Because the two halves are clamped independently, a lane mix-up is visible whenever the halves differ in sign or in size.

// File: rtl/sat_pack_unit.sv
module sat_pack_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_i,
  input  logic [$clog2(W)-1:0] imm_i,
  input  logic                 shtype_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic [W-1:0]         result_o,
  output logic                 sat_o
);
  localparam int SW = $clog2(W);
  localparam int H  = W / 2;
  localparam logic [2:0] OP_SSAT = 3'd0, OP_USAT = 3'd1, OP_SSAT16 = 3'd2,
                         OP_USAT16 = 3'd3, OP_PKBT = 3'd4, OP_PKTB = 3'd5;
  localparam logic [W:0]  UNIT = {{W{1'b0}}, 1'b1};
  localparam logic [SW:0] N1   = (SW+1)'(1);

  function automatic logic [W:0] clamp(input logic [W-1:0] x, input logic [SW:0] n,
                                       input logic uns);
    logic signed [W:0] xe, hi, lo;
    xe = $signed({x[W-1], x});
    if (uns) begin
      hi = (UNIT << n) - UNIT;
      lo = '0;
    end else begin
      hi = (UNIT << (n - N1)) - UNIT;
      lo = ~hi;
    end
    if (xe > hi)      return {1'b1, hi[W-1:0]};
    else if (xe < lo) return {1'b1, lo[W-1:0]};
    else              return {1'b0, x};
  endfunction

  logic [W-1:0] sh_in, sh_out;
  logic         sh_asr;
  assign sh_in  = (op_i == OP_PKBT || op_i == OP_PKTB) ? b_i : a_i;
  assign sh_asr = (op_i == OP_PKTB) ? 1'b1 : (op_i == OP_PKBT) ? 1'b0 : shtype_i;

  always_comb begin
    if (!sh_asr)             sh_out = sh_in << shamt_i;
    else if (shamt_i == '0)  sh_out = {W{sh_in[W-1]}};
    else                     sh_out = $signed(sh_in) >>> shamt_i;
  end

  logic         uns;
  logic [SW:0]  n_w, n_h;
  logic [W:0]   cw, clo, chi;
  assign uns = (op_i == OP_USAT) || (op_i == OP_USAT16);
  assign n_w = uns ? {1'b0, imm_i} : {1'b0, imm_i} + N1;
  assign n_h = uns ? {2'b00, imm_i[SW-2:0]} : {2'b00, imm_i[SW-2:0]} + N1;
  assign cw  = clamp(sh_out, n_w, uns);
  assign clo = clamp({{H{a_i[H-1]}}, a_i[H-1:0]}, n_h, uns);
  assign chi = clamp({{H{a_i[W-1]}}, a_i[W-1:H]}, n_h, uns);

  logic [W-1:0] res_d;
  logic         sat_d;
  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    case (op_i)
      OP_SSAT, OP_USAT: begin
        res_d = cw[W-1:0];
        sat_d = cw[W];
      end
      OP_SSAT16, OP_USAT16: begin
        res_d = {chi[H-1:0], clo[H-1:0]};
        sat_d = chi[W] | clo[W];
      end
      OP_PKBT: res_d = {sh_out[W-1:H], a_i[H-1:0]};
      OP_PKTB: res_d = {a_i[W-1:H], sh_out[H-1:0]};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      sat_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      sat_o    <= sat_d;
    end
  end
endmodule

// File: rtl/sat_pack_unit_chk.sv
module sat_pack_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           op_i,
  input logic [$clog2(W)-1:0] imm_i,
  input logic                 shtype_i,
  input logic [$clog2(W)-1:0] shamt_i,
  input logic [W-1:0]         a_i,
  input logic [W-1:0]         b_i,
  input logic [W-1:0]         result_o,
  input logic                 sat_o
);
  localparam int H = W / 2;

  p_pack_noq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 || op_i == 3'd5) |=> !sat_o);

  p_usat_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1) |=> !result_o[W-1]);

  p_usat16_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3) |=> (!result_o[W-1] && !result_o[H-1]));

  p_pkbt_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |=> result_o[H-1:0] == $past(a_i[H-1:0]));

  p_pktb_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd5) |=> result_o[W-1:H] == $past(a_i[W-1:H]));

  p_ssat_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && imm_i == '1 && !shtype_i && shamt_i == '0)
      |=> (result_o == $past(a_i) && !sat_o));

  p_unused_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i[2:1] == 2'b11) |=> (result_o == '0 && !sat_o));

  p_shift_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && $past(op_i) == 3'd2 && $stable(a_i) && $stable(imm_i[3:0]))
      |=> $stable(result_o));
endmodule

bind sat_pack_unit sat_pack_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_sat_pack_unit.sv
module sim_sat_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [4:0]  imm_i = '0;
  logic        shtype_i = 1'b0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        sat_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sat_pack_unit u0 (.*);

  function automatic longint shv(input logic [31:0] v, input bit asr, input logic [4:0] s);
    logic [31:0] t;
    if (!asr) begin
      t = v << s;
      return longint'($signed(t));
    end
    if (s == 0) return v[31] ? -64'sd1 : 64'sd0;
    return longint'($signed(v)) >>> s;
  endfunction

  function automatic void sat(input longint x, input int n, input bit uns,
                              output longint y, output bit q);
    longint hi, lo;
    hi = uns ? (64'sd1 <<< n) - 1 : (64'sd1 <<< (n - 1)) - 1;
    lo = uns ? 64'sd0 : -hi - 1;
    q = 1'b0;
    y = x;
    if (x > hi) begin y = hi; q = 1'b1; end
    if (x < lo) begin y = lo; q = 1'b1; end
  endfunction

  function automatic void model(input logic [2:0] op, input logic [4:0] imm, input bit st,
                                input logic [4:0] sh, input logic [31:0] a, b,
                                output logic [31:0] r, output bit q);
    longint y0, y1, t;
    bit q0, q1;
    r = '0; q = 1'b0;
    case (op)
      3'd0: begin sat(shv(a, st, sh), int'(imm) + 1, 1'b0, y0, q); r = y0[31:0]; end
      3'd1: begin sat(shv(a, st, sh), int'(imm), 1'b1, y0, q); r = y0[31:0]; end
      3'd2, 3'd3: begin
        sat(longint'($signed(a[15:0])),  int'(imm[3:0]) + (op == 3'd2 ? 1 : 0), op == 3'd3, y0, q0);
        sat(longint'($signed(a[31:16])), int'(imm[3:0]) + (op == 3'd2 ? 1 : 0), op == 3'd3, y1, q1);
        r = {y1[15:0], y0[15:0]};
        q = q0 | q1;
      end
      3'd4: begin t = shv(b, 1'b0, sh); r = {t[31:16], a[15:0]}; end
      3'd5: begin t = shv(b, 1'b1, sh); r = {a[31:16], t[15:0]}; end
      default: ;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op, input bit st);
    case (op)
      3'd0: return st ? "R3/R5" : "R3";
      3'd1: return st ? "R4/R5" : "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [4:0] imm, input bit st,
                     input logic [4:0] sh, input logic [31:0] a, b, input string tag);
    logic [31:0] er;
    bit eq;
    @(negedge clk);
    op_i = op; imm_i = imm; shtype_i = st; shamt_i = sh; a_i = a; b_i = b;
    model(op, imm, st, sh, a, b, er, eq);
    @(negedge clk);
    checks++;
    if (result_o !== er) begin
      fails++;
      $display("FAIL %s R2 result op=%0d act=%h exp=%h", tag, op, result_o, er);
    end
    checks++;
    if (sat_o !== eq) begin
      fails++;
      $display("FAIL %s R10 sat op=%0d act=%b exp=%b", tag, op, sat_o, eq);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #25;
    checks++;
    if (result_o !== 32'h0 || sat_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset act=%h/%b exp=0/0", result_o, sat_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (result_o !== 32'h0 || sat_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 after release act=%h/%b exp=0/0", result_o, sat_o);
    end
    run(3'd0, 5'd7, 0, 5'd0, 32'd127, 0, "R3 at max");
    run(3'd0, 5'd7, 0, 5'd0, 32'd128, 0, "R3 one past max");
    run(3'd0, 5'd7, 0, 5'd0, -32'sd129, 0, "R3 below min");
    run(3'd0, 5'd0, 0, 5'd0, 32'd1, 0, "R3 n=1");
    run(3'd0, 5'd31, 0, 5'd0, 32'h8000_0000, 0, "R3 pass through");
    run(3'd1, 5'd8, 0, 5'd0, -32'sd5, 0, "R4 negative");
    run(3'd1, 5'd8, 0, 5'd0, 32'd300, 0, "R4 high");
    run(3'd1, 5'd0, 0, 5'd0, 32'd1, 0, "R4 n=0");
    run(3'd0, 5'd31, 1, 5'd0, 32'h8000_1234, 0, "R5 asr by 32");
    run(3'd0, 5'd15, 0, 5'd4, 32'h0000_1000, 0, "R5 lsl clamp");
    run(3'd2, 5'd7, 1, 5'd9, {16'h7fff, 16'h8000}, 0, "R6 both lanes");
    run(3'd2, 5'd23, 0, 5'd0, {16'h0010, 16'hfff0}, 0, "R6 imm4 ignored");
    run(3'd3, 5'd4, 0, 5'd0, {16'h8000, 16'h000f}, 0, "R7 lanes");
    run(3'd4, 5'd0, 1, 5'd8, 32'hAAAA_5555, 32'h0012_3456, "R8 pack");
    run(3'd5, 5'd0, 0, 5'd0, 32'hAAAA_5555, 32'h8000_0000, "R9 asr 32");
    run(3'd5, 5'd0, 0, 5'd4, 32'hAAAA_5555, 32'h0001_2340, "R9 shifted");
    run(3'd6, 5'd3, 0, 5'd1, 32'hffff_ffff, 32'h1, "R11 op6");
    run(3'd7, 5'd3, 1, 5'd1, 32'h7fff_ffff, 32'h1, "R11 op7");
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [31:0] a;
      bit st;
      op = 3'($urandom_range(0, 7));
      st = 1'($urandom);
      a = $urandom;
      if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(0, 31);
      run(op, 5'($urandom), st, 5'($urandom), a, $urandom, req_of(op, st));
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule